// File: doc/BRIEF.md
# Minimal 8-bit RISC execution core

This block is a small processor core with separate program and register storage. It fetches one 16-bit instruction word per cycle from an external read-only program memory. The memory is read combinationally at the address the core drives. The core keeps thirty-two 8-bit general registers and a single carry flag. It executes a small instruction subset: load immediate, register copy, add, add with carry, increment, unsigned 8x8 multiply and PC-relative jump. A shift left is coded as a register added to itself. Every other word behaves as a no-operation.

Register numbers are taken from the packed opcode fields. In the two-register forms, the fifth bit of each register number sits apart from its lower four bits. Each instruction has a fixed cycle cost. Multiply and jump cost two cycles: the program counter holds for one extra cycle before it moves. A debug port reads any register combinationally and shows the program counter, so a host or bench can inspect the state.

Top module: `tiny8_core`

## Requirements
- R1: While reset is high, at every clock edge the program counter, all 32 registers and the carry flag are cleared, and any pending stall is dropped.
- R2: imem_addr always equals the program counter. The word on imem_data in a cycle is executed at the next rising edge, unless that cycle is the second (stall) cycle of a two-cycle instruction.
- R3: Load immediate, pattern 1110 KKKK dddd KKKK, writes the byte {high K nibble, low K nibble} into register 16+dddd. It takes 1 cycle and leaves carry unchanged (0xE015 loads 5 into R17).
- R4: Add, pattern 0000 11rd dddd rrrr, has destination index {bit 8, bits 7:4} and source index {bit 9, bits 3:0}. It writes (Rd+Rr) mod 256 to Rd, sets carry to bit 8 of the sum and takes 1 cycle. Adding a register to itself is the shift left, and its carry is the old bit 7.
- R5: Add with carry, pattern 0001 11rd dddd rrrr with the same fields as R4, writes (Rd+Rr+carry) mod 256 to Rd and sets carry to bit 8 of that sum.
- R6: Copy, pattern 0010 11rd dddd rrrr with the same fields as R4, writes Rr to Rd and leaves carry unchanged (0x2D00 copies R0 into R16).
- R7: Increment, pattern 1001 010d dddd 0011, writes (Rd+1) mod 256 to Rd and leaves carry unchanged.
- R8: Multiply, pattern 1001 11rd dddd rrrr with the same fields as R4, writes the unsigned 16-bit product, high byte to R1 and low byte to R0. It sets carry to product bit 15. It takes 2 cycles: the program counter holds after the first edge and advances by one after the second.
- R9: Relative jump, pattern 1100 kkkk kkkk kkkk with k a 12-bit two's-complement offset, sets the program counter to PC+k+1 after two edges. The counter holds after the first edge, so 0xCFFF loops on itself.
- R10: Any other word advances the program counter by one in 1 cycle and changes no register and no carry.
- R11: dbg_reg_data shows the register selected by dbg_reg_sel combinationally, and dbg_pc shows the program counter.
- R12: The ten-word program E015 E026 9F11 2D00 9F12 0C00 0D00 9F22 0D00 CFFF, started at address 0, reaches address 9 after exactly 12 edges. It then stays there, with R16=121, R17=5, R18=6, R0=36 and R1=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Program memory word address (the program counter) |
| imem_data | input | 16 | Instruction word read at imem_addr |
| dbg_reg_sel | input | 5 | Register number for the debug read |
| dbg_reg_data | output | 8 | Contents of the selected register |
| dbg_pc | output | PC_W | Current program counter |

## Verification
The assertions assume three things about the inputs. Reset is held for at least one edge before execution starts. imem_data carries a defined word in every cycle and depends only on imem_addr. They also take the program counter width to be at least the 12-bit jump offset. The bench keeps to these assumptions by modelling program memory as an array read combinationally, filling every unused word with zero (a no-operation). It drives reset and the debug select only on falling edges. Results are read back only through the debug port. The carry flag is made visible with an add-with-carry of a cleared register to itself.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

    localparam int INSN_W = 16;
    localparam int DATA_W = 8;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);
    localparam int JOFF_W = 12;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_LDI,
        OP_ADD,
        OP_ADC,
        OP_MOV,
        OP_INC,
        OP_MUL,
        OP_RJMP
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [RIDX_W-1:0]  rd;
        logic [RIDX_W-1:0]  rr;
        logic [DATA_W-1:0]  imm;
        logic [JOFF_W-1:0]  off;
        logic               two_cycle;
    } insn_t;

    typedef struct packed {
        logic                we;
        logic [RIDX_W-1:0]   wa;
        logic [DATA_W-1:0]   wd;
        logic                pair_we;
        logic [2*DATA_W-1:0] pair_wd;
        logic                c_we;
        logic                c_new;
    } wb_t;

    // Two-cycle instructions: multiply and jump.
    function automatic logic costs_two(input op_e op);
        return (op == OP_MUL) || (op == OP_RJMP);
    endfunction

    // Field extraction from a packed 16-bit word.
    function automatic insn_t decode_word(input logic [INSN_W-1:0] w);
        insn_t d;
        d.op  = OP_NOP;
        d.rd  = {w[8], w[7:4]};
        d.rr  = {w[9], w[3:0]};
        d.imm = {w[11:8], w[3:0]};
        d.off = w[11:0];
        if (w[15:12] == 4'hE) begin
            d.op = OP_LDI;
            d.rd = {1'b1, w[7:4]};
        end else if (w[15:12] == 4'hC) begin
            d.op = OP_RJMP;
        end else begin
            case (w[15:10])
                6'b000011: d.op = OP_ADD;
                6'b000111: d.op = OP_ADC;
                6'b001011: d.op = OP_MOV;
                6'b100111: d.op = OP_MUL;
                default: begin
                    if (w[15:9] == 7'b1001010 && w[3:0] == 4'b0011)
                        d.op = OP_INC;
                end
            endcase
        end
        d.two_cycle = costs_two(d.op);
        return d;
    endfunction

endpackage

// File: rtl/tiny8_decode.sv
module tiny8_decode
    import tiny8_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output insn_t             insn
);
    always_comb begin
        insn = decode_word(word);
    end
endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu
    import tiny8_pkg::*;
(
    input  insn_t             insn,
    input  logic              issue,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output wb_t               wb
);
    logic [DATA_W:0]     sum;
    logic [2*DATA_W-1:0] prod;
    logic                cin_eff;

    assign cin_eff = (insn.op == OP_ADC) ? cin : 1'b0;
    assign sum     = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin_eff};
    assign prod    = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};

    always_comb begin
        wb    = '0;
        wb.wa = insn.rd;
        case (insn.op)
            OP_LDI: begin
                wb.we = 1'b1;
                wb.wd = insn.imm;
            end
            OP_ADD, OP_ADC: begin
                wb.we    = 1'b1;
                wb.wd    = sum[DATA_W-1:0];
                wb.c_we  = 1'b1;
                wb.c_new = sum[DATA_W];
            end
            OP_MOV: begin
                wb.we = 1'b1;
                wb.wd = b;
            end
            OP_INC: begin
                wb.we = 1'b1;
                wb.wd = a + DATA_W'(1);
            end
            OP_MUL: begin
                wb.pair_we = 1'b1;
                wb.pair_wd = prod;
                wb.c_we    = 1'b1;
                wb.c_new   = prod[2*DATA_W-1];
            end
            default: ;
        endcase
        if (!issue) begin
            wb.we      = 1'b0;
            wb.pair_we = 1'b0;
            wb.c_we    = 1'b0;
        end
    end
endmodule

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
    parameter int N_REGS = 32,
    parameter int D_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [$clog2(N_REGS)-1:0] wa,
    input  logic [D_W-1:0]            wd,
    input  logic                      pair_we,
    input  logic [2*D_W-1:0]          pair_wd,
    input  logic [$clog2(N_REGS)-1:0] ra,
    input  logic [$clog2(N_REGS)-1:0] rb,
    input  logic [$clog2(N_REGS)-1:0] rdbg,
    output logic [D_W-1:0]            qa,
    output logic [D_W-1:0]            qb,
    output logic [D_W-1:0]            qdbg
);
    localparam int IDX_W = $clog2(N_REGS);

    logic [D_W-1:0] regs [N_REGS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_REGS; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (pair_we && i < 2) begin
                regs[i] <= pair_wd[i*D_W +: D_W];
            end else if (we && wa == IDX_W'(i)) begin
                regs[i] <= wd;
            end
        end
    end

    assign qa   = regs[ra];
    assign qb   = regs[rb];
    assign qdbg = regs[rdbg];
endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
    import tiny8_pkg::*;
#(
    parameter int PC_W = 12  // at least JOFF_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [INSN_W-1:0] imem_data,
    input  logic [RIDX_W-1:0] dbg_reg_sel,
    output logic [DATA_W-1:0] dbg_reg_data,
    output logic [PC_W-1:0]   dbg_pc
);
    logic [PC_W-1:0]        pc_q;
    logic [PC_W-1:0]        pc_pend_q;
    logic                   busy_q;
    logic                   carry_q;
    logic                   issue;
    insn_t                  insn;
    wb_t                    wb;
    logic [DATA_W-1:0]      op_a;
    logic [DATA_W-1:0]      op_b;
    logic signed [PC_W-1:0] off_x;
    logic [PC_W-1:0]        pc_next;

    assign issue = !busy_q;

    tiny8_decode u_dec (
        .word (imem_data),
        .insn (insn)
    );

    tiny8_regfile #(.N_REGS(NREG), .D_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wb.we),
        .wa      (wb.wa),
        .wd      (wb.wd),
        .pair_we (wb.pair_we),
        .pair_wd (wb.pair_wd),
        .ra      (insn.rd),
        .rb      (insn.rr),
        .rdbg    (dbg_reg_sel),
        .qa      (op_a),
        .qb      (op_b),
        .qdbg    (dbg_reg_data)
    );

    tiny8_alu u_alu (
        .insn  (insn),
        .issue (issue),
        .a     (op_a),
        .b     (op_b),
        .cin   (carry_q),
        .wb    (wb)
    );

    assign off_x   = PC_W'(signed'(insn.off));
    assign pc_next = (insn.op == OP_RJMP) ? pc_q + off_x + PC_W'(1)
                                          : pc_q + PC_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            pc_pend_q <= '0;
            busy_q    <= 1'b0;
            carry_q   <= 1'b0;
        end else begin
            if (wb.c_we) carry_q <= wb.c_new;
            if (busy_q) begin
                pc_q   <= pc_pend_q;
                busy_q <= 1'b0;
            end else if (insn.two_cycle) begin
                pc_pend_q <= pc_next;
                busy_q    <= 1'b1;
            end else begin
                pc_q <= pc_next;
            end
        end
    end

    assign imem_addr = pc_q;
    assign dbg_pc    = pc_q;
endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk
    import tiny8_pkg::*;
#(
    parameter int PC_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input op_e               op,
    input logic              two_cycle,
    input logic [PC_W-1:0]   pc,
    input logic [JOFF_W-1:0] off,
    input logic              carry
);
    // R1
    a_r1_pc_cleared: assert property (@(posedge clk)
        $past(rst) |-> pc == '0);

    // R10 / R2: single-cycle words step by one
    a_r10_step_one: assert property (@(posedge clk) disable iff (rst)
        (!busy && !two_cycle) |=> pc == $past(pc) + PC_W'(1));

    // R8: two-cycle words hold the counter one edge
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (!busy && two_cycle) |=> (busy && $stable(pc)));

    // R8: a stall lasts exactly one cycle
    a_r8_single_stall: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R9
    a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
        (!busy && op == OP_RJMP) |=> ##1
        (pc == $past(pc, 2) + PC_W'(signed'($past(off, 2))) + PC_W'(1)));

    // R7
    a_r7_inc_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        (!busy && op == OP_INC) |=> $stable(carry));
endmodule

bind tiny8_core tiny8_core_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy_q),
    .op        (insn.op),
    .two_cycle (insn.two_cycle),
    .pc        (pc_q),
    .off       (insn.off),
    .carry     (carry_q)
);

// File: tb/sim_tiny8_core.sv
`timescale 1ns/100ps
module sim_tiny8_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] imem_addr;
    logic [15:0] imem_data;
    logic [4:0]  dbg_reg_sel = '0;
    logic [7:0]  dbg_reg_data;
    logic [11:0] dbg_pc;

    logic [15:0] mem [256];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    assign imem_data = mem[imem_addr[7:0]];

    tiny8_core #(.PC_W(12)) u0 (
        .clk          (clk),
        .rst          (rst),
        .imem_addr    (imem_addr),
        .imem_data    (imem_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_pc       (dbg_pc)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [15:0] e_ldi(input logic [4:0] d, input logic [7:0] k);
        return {4'hE, k[7:4], d[3:0], k[3:0]};
    endfunction
    function automatic logic [15:0] e_rr(input logic [5:0] t, input logic [4:0] d, input logic [4:0] r);
        return {t, r[4], d[4], d[3:0], r[3:0]};
    endfunction
    function automatic logic [15:0] e_inc(input logic [4:0] d);
        return {7'b1001010, d[4], d[3:0], 4'b0011};
    endfunction
    localparam logic [5:0] T_ADD = 6'b000011;
    localparam logic [5:0] T_ADC = 6'b000111;
    localparam logic [5:0] T_MOV = 6'b001011;
    localparam logic [5:0] T_MUL = 6'b100111;
    localparam logic [15:0] W_SELF = 16'hCFFF;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    task automatic start_prog();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic get(input int idx, output int v);
        dbg_reg_sel = 5'(idx);
        #1;
        v = int'(dbg_reg_data);
    endtask

    task automatic chk_reg(input string tag, input int idx, input int exp);
        int v;
        get(idx, v);
        chk(tag, v, exp);
    endtask

    initial begin
        int v;
        // R12 / R2 / R8 / R9: the worked program, cycle by cycle
        clear_mem();
        mem[0] = 16'hE015; mem[1] = 16'hE026; mem[2] = 16'h9F11; mem[3] = 16'h2D00;
        mem[4] = 16'h9F12; mem[5] = 16'h0C00; mem[6] = 16'h0D00; mem[7] = 16'h9F22;
        mem[8] = 16'h0D00; mem[9] = 16'hCFFF;
        start_prog();
        chk("R2 pc at start", int'(dbg_pc), 0);
        repeat (2) @(negedge clk);
        chk("R3 pc after two loads", int'(dbg_pc), 2);
        chk_reg("R3 R17 loaded", 17, 5);
        @(negedge clk);
        chk("R8 pc holds during multiply", int'(dbg_pc), 2);
        chk_reg("R8 R0 after first multiply", 0, 25);
        @(negedge clk);
        chk("R8 pc after multiply", int'(dbg_pc), 3);
        repeat (8) @(negedge clk);
        chk("R12 pc at loop after 12 edges", int'(dbg_pc), 9);
        chk_reg("R12 R16", 16, 121);
        chk_reg("R12 R17", 17, 5);
        chk_reg("R12 R18", 18, 6);
        chk_reg("R12 R0", 0, 36);
        chk_reg("R12 R1", 1, 0);
        @(negedge clk);
        chk("R9 self jump holds", int'(dbg_pc), 9);
        repeat (3) @(negedge clk);
        chk("R9 self jump stays", int'(dbg_pc), 9);
        chk("R11 dbg_pc equals imem_addr", int'(dbg_pc), int'(imem_addr));

        // R1: reset clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 pc cleared", int'(dbg_pc), 0);
        for (int r = 0; r < 32; r++) chk_reg("R1 register cleared", r, 0);
        rst = 1'b0;

        // R4 / R5: add and add with carry sweep
        for (int a = 0; a < 256; a += 17) begin
            for (int b = 0; b < 256; b += 29) begin
                int x, y, s, t;
                x = (a * 3 + 7) & 255;
                y = (b * 5 + 1) & 255;
                s = a + b;
                t = x + y + (s >> 8);
                clear_mem();
                mem[0] = e_ldi(16, 8'(a));
                mem[1] = e_ldi(17, 8'(b));
                mem[2] = e_rr(T_ADD, 16, 17);
                mem[3] = e_ldi(19, 8'(x));
                mem[4] = e_ldi(20, 8'(y));
                mem[5] = e_rr(T_ADC, 19, 20);
                mem[6] = e_ldi(21, 8'h00);
                mem[7] = e_rr(T_ADC, 21, 21);
                mem[8] = W_SELF;
                start_prog();
                repeat (14) @(negedge clk);
                chk_reg("R4 add sum", 16, s & 255);
                chk_reg("R5 add-with-carry sum", 19, t & 255);
                chk_reg("R5 add-with-carry carry out", 21, t >> 8);
            end
        end

        // R4: shift left as self add, carry is old bit 7
        for (int a = 0; a < 256; a++) begin
            clear_mem();
            mem[0] = e_ldi(16, 8'(a));
            mem[1] = e_rr(T_ADD, 16, 16);
            mem[2] = e_ldi(18, 8'h00);
            mem[3] = e_rr(T_ADC, 18, 18);
            mem[4] = W_SELF;
            start_prog();
            repeat (7) @(negedge clk);
            chk_reg("R4 shift result", 16, (a << 1) & 255);
            chk_reg("R4 shift carry", 18, a >> 7);
        end

        // R8: multiply with split-field high registers
        for (int a = 0; a < 256; a += 13) begin
            for (int b = 0; b < 256; b += 37) begin
                int p;
                p = a * b;
                clear_mem();
                mem[0] = e_ldi(31, 8'(a));
                mem[1] = e_ldi(30, 8'(b));
                mem[2] = e_rr(T_MUL, 31, 30);
                mem[3] = e_ldi(21, 8'h00);
                mem[4] = e_rr(T_ADC, 21, 21);
                mem[5] = W_SELF;
                start_prog();
                repeat (9) @(negedge clk);
                chk_reg("R8 product low", 0, p & 255);
                chk_reg("R8 product high", 1, p >> 8);
                chk_reg("R8 product carry", 21, p >> 15);
            end
        end

        // R7: increment wraps and keeps carry
        for (int a = 0; a < 256; a++) begin
            clear_mem();
            mem[0] = e_ldi(16, 8'(a));
            mem[1] = e_ldi(17, (a & 1) ? 8'hFF : 8'h01);
            mem[2] = e_rr(T_ADD, 17, 17);
            mem[3] = e_inc(16);
            mem[4] = e_ldi(18, 8'h00);
            mem[5] = e_rr(T_ADC, 18, 18);
            mem[6] = W_SELF;
            start_prog();
            repeat (9) @(negedge clk);
            chk_reg("R7 increment value", 16, (a + 1) & 255);
            chk_reg("R7 increment keeps carry", 18, a & 1);
        end

        // R6 / R11: copy through low registers, carry kept
        for (int k = 0; k < 4; k++) begin
            logic [7:0] pv;
            pv = (k == 0) ? 8'hA5 : (k == 1) ? 8'h00 : (k == 2) ? 8'hFF : 8'h3C;
            clear_mem();
            mem[0] = e_ldi(31, pv);
            mem[1] = e_rr(T_MOV, 5, 31);
            mem[2] = e_rr(T_MOV, 20, 5);
            mem[3] = e_ldi(16, 8'hFF);
            mem[4] = e_rr(T_ADD, 16, 16);
            mem[5] = e_rr(T_MOV, 7, 20);
            mem[6] = e_ldi(22, 8'h00);
            mem[7] = e_rr(T_ADC, 22, 22);
            mem[8] = W_SELF;
            start_prog();
            repeat (12) @(negedge clk);
            chk_reg("R6 copy to R5", 5, int'(pv));
            chk_reg("R6 copy to R20", 20, int'(pv));
            chk_reg("R6 copy to R7", 7, int'(pv));
            chk_reg("R6 copy keeps carry", 22, 1);
        end

        // R10: undecoded words are single-cycle no-operations
        clear_mem();
        mem[0] = e_ldi(16, 8'h3C);
        mem[1] = 16'hFFFF;
        mem[2] = 16'h0001;
        mem[3] = 16'h9408;
        mem[4] = e_ldi(17, 8'h01);
        mem[5] = W_SELF;
        start_prog();
        repeat (4) @(negedge clk);
        chk("R10 pc after three no-ops", int'(dbg_pc), 4);
        repeat (4) @(negedge clk);
        chk_reg("R10 R16 untouched", 16, 8'h3C);
        chk_reg("R10 R17 loaded after no-ops", 17, 1);
        for (int r = 0; r < 32; r++) begin
            if (r != 16 && r != 17) chk_reg("R10 other register untouched", r, 0);
        end

        // R9: forward jump skips a word, two-cycle timing
        clear_mem();
        mem[0] = e_ldi(16, 8'h01);
        mem[1] = 16'hC001;
        mem[2] = e_ldi(16, 8'h77);
        mem[3] = e_ldi(17, 8'h02);
        mem[4] = W_SELF;
        start_prog();
        @(negedge clk);
        chk("R9 pc before jump", int'(dbg_pc), 1);
        @(negedge clk);
        chk("R9 pc holds on jump", int'(dbg_pc), 1);
        @(negedge clk);
        chk("R9 pc at target", int'(dbg_pc), 3);
        repeat (5) @(negedge clk);
        chk_reg("R9 skipped word not executed", 16, 1);
        chk_reg("R9 target executed", 17, 2);
        get(16, v);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule